// File: doc/BRIEF.md
# Scan Velocity Modulation Drive Processor

This block turns a stream of digital RGB pixels into a signed drive sample for a scan-velocity-modulation coil amplifier. Each pixel is first reduced to a luminance value with a fixed weighting. A difference filter then compares that luminance with the value a programmable number of pixels earlier, so the result is large on horizontal brightness edges and near zero on flat areas. Small differences are cored away as noise, the rest is scaled by a fixed-point gain and clipped by a symmetric limit. The final sample can be shifted in time in half-pixel steps, so that the coil current lines up with the edge on the screen.

Two complete parameter sets are held, each with its own filter span, coring threshold, gain and limit. A per-pixel select bit, the same one that picks between video and on-screen-display RGB upstream, chooses which set acts on each pixel, and that choice travels down the pipeline with the pixel. The pipeline advances only on pixels marked valid. The 8-bit signed output feeds a converter outside the block.

Top module: `svm_proc`

## Requirements
- R1: The luminance of each valid pixel is floor((red + 2*green + blue) / 4), computed from the 10-bit unsigned channels.
- R2: The difference for pixel i is Y(i) - Y(i-N), where N is the span of the pixel's set; span codes 1 to 6 give N directly, code 0 acts as 1 and code 7 acts as 6, and pixels before the first one after reset count as Y = 0.
- R3: A difference whose magnitude is less than or equal to the coring threshold of the pixel's set becomes zero; larger differences pass unchanged.
- R4: The cored difference is multiplied by the set's unsigned gain, read as 4 integer and 4 fraction bits, and shifted right arithmetically by 4 (rounding toward minus infinity).
- R5: The scaled value is clamped to the range -limit to +limit, where limit is the set's 7-bit unsigned limit; a limit of 0 forces the sample to 0.
- R6: With select low a pixel uses set A, with select high set B; the set chosen at the pixel's entry governs its span, coring, gain and limit even if select changes later.
- R7: The delay code is a 4-bit two's-complement number d of half-pixel steps, -8 read as -7; with h = 8 + d, the output after valid edge m is S(m-4-h/2) for even h and floor((S(m-4-(h-1)/2) + S(m-5-(h-1)/2)) / 2) for odd h, where S(j) is the clamped sample of pixel j (0 for j < 0) and m counts valid pixels from 0 after reset.
- R8: A clock edge with valid low changes no state: the output holds and the RGB and select inputs of that cycle are ignored.
- R9: Reset clears the output and all pixel history to zero.
- R10: The output is 8-bit two's complement and never takes the value -128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Pixel on the RGB inputs is valid; pipeline advances |
| red | input | 10 | Red channel, unsigned |
| grn | input | 10 | Green channel, unsigned |
| blu | input | 10 | Blue channel, unsigned |
| set_sel | input | 1 | Per-pixel parameter set choice (0 = A, 1 = B) |
| span_a | input | 3 | Filter span code, set A |
| core_a | input | 10 | Coring threshold, set A |
| gain_a | input | 8 | Gain in 4.4 fixed point, set A |
| lim_a | input | 7 | Output magnitude limit, set A |
| span_b | input | 3 | Filter span code, set B |
| core_b | input | 10 | Coring threshold, set B |
| gain_b | input | 8 | Gain in 4.4 fixed point, set B |
| lim_b | input | 7 | Output magnitude limit, set B |
| dly_half | input | 4 | Signed delay trim in half-pixel steps |
| svm_out | output | 8 | Signed drive sample |

## Verification
The half-pixel averaging and the per-pixel set switch meet in the same output cycle when the two neighbouring samples being averaged came from pixels that used different sets. The bench provokes this by toggling the select bit at random on every pixel while an odd half-step delay is programmed and the two sets have very different spans, gains and limits. Each output is judged against a model that looks up the set each contributing pixel carried at entry, computes both samples separately, and only then averages them with floor rounding.

// File: rtl/svm_pkg.sv
package svm_pkg;
  typedef enum logic {
    SET_A = 1'b0,
    SET_B = 1'b1
  } svm_set_e;

  localparam int SVM_BASE_DLY = 4;
  localparam int SVM_GAIN_FRAC = 4;
endpackage

// File: rtl/svm_luma_diff.sv
module svm_luma_diff #(
  parameter int PIX_W    = 10,
  parameter int MAX_SPAN = 6,
  parameter int SPAN_W   = 3,
  localparam int DIFF_W  = PIX_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic [PIX_W-1:0]         red,
  input  logic [PIX_W-1:0]         grn,
  input  logic [PIX_W-1:0]         blu,
  input  svm_pkg::svm_set_e        sel_in,
  input  logic [SPAN_W-1:0]        span_a,
  input  logic [SPAN_W-1:0]        span_b,
  output logic signed [DIFF_W-1:0] diff_out,
  output svm_pkg::svm_set_e        sel_out
);
  import svm_pkg::*;

  logic [PIX_W+1:0]   luma_sum;
  logic [PIX_W-1:0]   luma_now;
  logic [PIX_W-1:0]   y_q;
  svm_set_e           sel_q;
  logic [PIX_W-1:0]   hist [MAX_SPAN];
  logic [SPAN_W-1:0]  span_raw;
  logic [SPAN_W-1:0]  span_eff;
  logic [PIX_W-1:0]   y_old;

  assign luma_sum = {2'b00, red} + {1'b0, grn, 1'b0} + {2'b00, blu};
  assign luma_now = luma_sum[PIX_W+1:2];

  assign span_raw = (sel_q == SET_B) ? span_b : span_a;

  always_comb begin
    if (span_raw == '0)
      span_eff = SPAN_W'(1);
    else if (span_raw > SPAN_W'(MAX_SPAN))
      span_eff = SPAN_W'(MAX_SPAN);
    else
      span_eff = span_raw;
  end

  always_comb begin
    y_old = '0;
    for (int i = 0; i < MAX_SPAN; i++) begin
      if (span_eff == SPAN_W'(i + 1)) y_old = hist[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y_q      <= '0;
      sel_q    <= SET_A;
      diff_out <= '0;
      sel_out  <= SET_A;
      for (int i = 0; i < MAX_SPAN; i++) hist[i] <= '0;
    end else if (en) begin
      y_q      <= luma_now;
      sel_q    <= svm_set_e'(sel_in);
      hist[0]  <= y_q;
      for (int i = 1; i < MAX_SPAN; i++) hist[i] <= hist[i-1];
      diff_out <= $signed({1'b0, y_q}) - $signed({1'b0, y_old});
      sel_out  <= sel_q;
    end
  end
endmodule

// File: rtl/svm_shape.sv
module svm_shape #(
  parameter int PIX_W  = 10,
  parameter int GAIN_W = 8,
  parameter int OUT_W  = 8,
  localparam int DIFF_W = PIX_W + 1,
  localparam int LIM_W  = OUT_W - 1,
  localparam int PROD_W = DIFF_W + GAIN_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic signed [DIFF_W-1:0] diff_in,
  input  svm_pkg::svm_set_e        sel_in,
  input  logic [PIX_W-1:0]         core_a,
  input  logic [PIX_W-1:0]         core_b,
  input  logic [GAIN_W-1:0]        gain_a,
  input  logic [GAIN_W-1:0]        gain_b,
  input  logic [LIM_W-1:0]         lim_a,
  input  logic [LIM_W-1:0]         lim_b,
  output logic signed [OUT_W-1:0]  samp_out
);
  import svm_pkg::*;

  logic [DIFF_W-1:0]        mag;
  logic [PIX_W-1:0]         core_sel;
  logic signed [DIFF_W-1:0] cored_q;
  svm_set_e                 sel_q;
  logic [GAIN_W-1:0]        gain_sel;
  logic [LIM_W-1:0]         lim_sel;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] scaled;
  logic signed [PROD_W-1:0] lim_pos;
  logic signed [PROD_W-1:0] clamped;

  assign core_sel = (sel_in == SET_B) ? core_b : core_a;
  assign mag      = diff_in[DIFF_W-1] ? DIFF_W'(-diff_in) : DIFF_W'(diff_in);

  assign gain_sel = (sel_q == SET_B) ? gain_b : gain_a;
  assign lim_sel  = (sel_q == SET_B) ? lim_b : lim_a;
  assign prod     = PROD_W'(cored_q) * $signed({{(PROD_W-GAIN_W){1'b0}}, gain_sel});
  assign scaled   = prod >>> SVM_GAIN_FRAC;
  assign lim_pos  = $signed({{(PROD_W-LIM_W){1'b0}}, lim_sel});

  always_comb begin
    if (scaled > lim_pos)
      clamped = lim_pos;
    else if (scaled < -lim_pos)
      clamped = -lim_pos;
    else
      clamped = scaled;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cored_q  <= '0;
      sel_q    <= SET_A;
      samp_out <= '0;
    end else if (en) begin
      cored_q  <= (mag <= {1'b0, core_sel}) ? '0 : diff_in;
      sel_q    <= sel_in;
      samp_out <= clamped[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/svm_frac_delay.sv
module svm_frac_delay #(
  parameter int OUT_W    = 8,
  parameter int DLY_W    = 4,
  parameter int BASE_DLY = svm_pkg::SVM_BASE_DLY,
  localparam int MAX_HALF = 2 * BASE_DLY + (2 ** (DLY_W - 1)) - 1,
  localparam int TAP_N    = MAX_HALF / 2 + 1,
  localparam int HALF_W   = $clog2(MAX_HALF + 1),
  localparam int IDX_W    = $clog2(TAP_N + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [OUT_W-1:0] samp_in,
  input  logic signed [DLY_W-1:0] dly_half,
  output logic signed [OUT_W-1:0] svm_out
);
  logic signed [OUT_W-1:0] taps [TAP_N+1];
  logic signed [OUT_W-1:0] line_q [TAP_N];
  logic signed [DLY_W-1:0] dly_eff;
  logic [HALF_W-1:0]       half_pos;
  logic [IDX_W-1:0]        idx;
  logic signed [OUT_W-1:0] near_s;
  logic signed [OUT_W-1:0] far_s;
  logic signed [OUT_W:0]   pair_sum;
  logic signed [OUT_W-1:0] result;

  assign taps[0] = samp_in;
  generate
    for (genvar t = 1; t <= TAP_N; t++) begin : g_tap
      assign taps[t] = line_q[t-1];
    end
  endgenerate

  assign dly_eff  = (dly_half == {1'b1, {(DLY_W-1){1'b0}}}) ? dly_half + 1'b1 : dly_half;
  assign half_pos = HALF_W'($signed(2 * BASE_DLY) + int'(dly_eff));
  assign idx      = IDX_W'(half_pos >> 1);

  always_comb begin
    near_s = '0;
    far_s  = '0;
    for (int t = 0; t < TAP_N; t++) begin
      if (idx == IDX_W'(t)) begin
        near_s = taps[t];
        far_s  = taps[t+1];
      end
    end
  end

  assign pair_sum = {near_s[OUT_W-1], near_s} + {far_s[OUT_W-1], far_s};
  assign result   = half_pos[0] ? pair_sum[OUT_W:1] : near_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      svm_out <= '0;
      for (int t = 0; t < TAP_N; t++) line_q[t] <= '0;
    end else if (en) begin
      line_q[0] <= samp_in;
      for (int t = 1; t < TAP_N; t++) line_q[t] <= line_q[t-1];
      svm_out <= result;
    end
  end
endmodule

// File: rtl/svm_proc.sv
module svm_proc #(
  parameter int PIX_W    = 10,
  parameter int MAX_SPAN = 6,
  parameter int GAIN_W   = 8,
  parameter int OUT_W    = 8,
  parameter int DLY_W    = 4,
  localparam int SPAN_W  = $clog2(MAX_SPAN + 2),
  localparam int LIM_W   = OUT_W - 1,
  localparam int DIFF_W  = PIX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  red,
  input  logic [PIX_W-1:0]  grn,
  input  logic [PIX_W-1:0]  blu,
  input  logic              set_sel,
  input  logic [SPAN_W-1:0] span_a,
  input  logic [PIX_W-1:0]  core_a,
  input  logic [GAIN_W-1:0] gain_a,
  input  logic [LIM_W-1:0]  lim_a,
  input  logic [SPAN_W-1:0] span_b,
  input  logic [PIX_W-1:0]  core_b,
  input  logic [GAIN_W-1:0] gain_b,
  input  logic [LIM_W-1:0]  lim_b,
  input  logic [DLY_W-1:0]  dly_half,
  output logic [OUT_W-1:0]  svm_out
);
  import svm_pkg::*;

  logic signed [DIFF_W-1:0] diff_w;
  svm_set_e                 sel_w;
  logic signed [OUT_W-1:0]  samp_w;
  logic signed [OUT_W-1:0]  out_w;

  svm_luma_diff #(
    .PIX_W(PIX_W), .MAX_SPAN(MAX_SPAN), .SPAN_W(SPAN_W)
  ) u_diff (
    .clk(clk), .rst(rst), .en(pix_valid),
    .red(red), .grn(grn), .blu(blu),
    .sel_in(svm_set_e'(set_sel)),
    .span_a(span_a), .span_b(span_b),
    .diff_out(diff_w), .sel_out(sel_w)
  );

  svm_shape #(
    .PIX_W(PIX_W), .GAIN_W(GAIN_W), .OUT_W(OUT_W)
  ) u_shape (
    .clk(clk), .rst(rst), .en(pix_valid),
    .diff_in(diff_w), .sel_in(sel_w),
    .core_a(core_a), .core_b(core_b),
    .gain_a(gain_a), .gain_b(gain_b),
    .lim_a(lim_a), .lim_b(lim_b),
    .samp_out(samp_w)
  );

  svm_frac_delay #(
    .OUT_W(OUT_W), .DLY_W(DLY_W), .BASE_DLY(SVM_BASE_DLY)
  ) u_dly (
    .clk(clk), .rst(rst), .en(pix_valid),
    .samp_in(samp_w), .dly_half($signed(dly_half)),
    .svm_out(out_w)
  );

  assign svm_out = out_w;
endmodule

// File: rtl/svm_proc_chk.sv
module svm_proc_chk #(
  parameter int OUT_W = 8,
  parameter int FLUSH = 14,
  localparam int LIM_W = OUT_W - 1,
  localparam int CNT_W = $clog2(FLUSH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             pix_valid,
  input logic [LIM_W-1:0] lim_a,
  input logic [LIM_W-1:0] lim_b,
  input logic [OUT_W-1:0] svm_out
);
  logic [CNT_W-1:0] zero_run;

  always_ff @(posedge clk) begin
    if (rst)
      zero_run <= '0;
    else if (lim_a != '0 || lim_b != '0)
      zero_run <= '0;
    else if (pix_valid && zero_run != CNT_W'(FLUSH))
      zero_run <= zero_run + 1'b1;
  end

  // R9: reset clears the output
  p_reset_clear_r9: assert property (@(posedge clk) rst |=> (svm_out == '0));

  // R8: no valid pixel, no change
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |=> $stable(svm_out));

  // R10: most negative code never appears
  p_no_min_code_r10: assert property (@(posedge clk) disable iff (rst)
    svm_out != {1'b1, {(OUT_W-1){1'b0}}});

  // R5: zero limits on both sets flush to a zero output
  p_zero_limit_r5: assert property (@(posedge clk) disable iff (rst)
    (zero_run == CNT_W'(FLUSH)) |-> (svm_out == '0));
endmodule

bind svm_proc svm_proc_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .pix_valid(pix_valid),
  .lim_a(lim_a), .lim_b(lim_b), .svm_out(svm_out)
);

// File: tb/sim_svm_proc.sv
`timescale 1ns/1ps
module sim_svm_proc;
  localparam int NPIX = 220;
  localparam int NPH  = 18;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pix_valid = 1'b0;
  logic [9:0] red = '0, grn = '0, blu = '0;
  logic       set_sel = 1'b0;
  logic [2:0] span_a = '0, span_b = '0;
  logic [9:0] core_a = '0, core_b = '0;
  logic [7:0] gain_a = '0, gain_b = '0;
  logic [6:0] lim_a = '0, lim_b = '0;
  logic [3:0] dly_half = '0;
  logic [7:0] svm_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int  y_arr [NPIX];
  bit  sel_arr [NPIX];
  int  vpct, pmode, smode;
  string tag;

  always #5 clk = ~clk;

  svm_proc u0 (
    .clk(clk), .rst(rst), .pix_valid(pix_valid),
    .red(red), .grn(grn), .blu(blu), .set_sel(set_sel),
    .span_a(span_a), .core_a(core_a), .gain_a(gain_a), .lim_a(lim_a),
    .span_b(span_b), .core_b(core_b), .gain_b(gain_b), .lim_b(lim_b),
    .dly_half(dly_half), .svm_out(svm_out)
  );

  function automatic int luma(int r, int g, int b);
    return (r + 2 * g + b) / 4;
  endfunction

  function automatic int samp(int j);
    int n, yp, d, cr, gn, lm, p;
    bit s;
    if (j < 0) return 0;
    s  = sel_arr[j];
    n  = s ? int'(span_b) : int'(span_a);
    cr = s ? int'(core_b) : int'(core_a);
    gn = s ? int'(gain_b) : int'(gain_a);
    lm = s ? int'(lim_b)  : int'(lim_a);
    if (n < 1) n = 1;
    if (n > 6) n = 6;
    yp = (j - n < 0) ? 0 : y_arr[j - n];
    d  = y_arr[j] - yp;
    if ((d < 0 ? -d : d) <= cr) d = 0;
    p = (d * gn) >>> 4;
    if (p > lm) p = lm;
    if (p < -lm) p = -lm;
    return p;
  endfunction

  function automatic int expect_out(int m);
    int dl, h, k;
    dl = int'($signed(dly_half));
    if (dl < -7) dl = -7;
    h = 8 + dl;
    k = h / 2;
    if (h % 2 == 1) return (samp(m - 4 - k) + samp(m - 5 - k)) >>> 1;
    return samp(m - 4 - k);
  endfunction

  task automatic check(string t, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  task automatic configure(int ph);
    span_a = 3'($urandom % 8);  span_b = 3'($urandom % 8);
    core_a = 10'($urandom % 48); core_b = 10'($urandom % 48);
    gain_a = 8'($urandom % 256); gain_b = 8'($urandom % 256);
    lim_a  = 7'($urandom % 128); lim_b  = 7'($urandom % 128);
    dly_half = 4'($urandom % 16);
    vpct = 100; pmode = 0; smode = 1; tag = "R10";
    case (ph)
      0: begin tag = "R1"; smode = 0; span_a = 1; core_a = 0; gain_a = 16; lim_a = 127; dly_half = 0; end
      1: begin tag = "R2"; span_a = 6; span_b = 0; core_a = 0; core_b = 0; gain_a = 16; gain_b = 16; lim_a = 127; lim_b = 127; dly_half = 0; end
      2: begin tag = "R2"; pmode = 1; span_a = 7; span_b = 4; core_a = 0; core_b = 0; gain_a = 8; gain_b = 8; lim_a = 127; lim_b = 127; end
      3: begin tag = "R3"; pmode = 2; core_a = 6; core_b = 0; gain_a = 64; gain_b = 64; span_a = 1; span_b = 2; lim_a = 127; lim_b = 127; end
      4: begin tag = "R4"; gain_a = 8'h1B; gain_b = 8'hFF; core_a = 0; core_b = 0; lim_a = 127; lim_b = 127; end
      5: begin tag = "R5"; pmode = 1; lim_a = 9; lim_b = 0; gain_a = 80; gain_b = 80; end
      6: begin tag = "R6"; span_a = 1; span_b = 6; gain_a = 4; gain_b = 255; lim_a = 20; lim_b = 120; dly_half = 4'd3; end
      7: begin tag = "R7"; dly_half = 4'b1001; end
      8: begin tag = "R7"; dly_half = 4'd7; end
      9: begin tag = "R7"; dly_half = 4'b1000; end
      10: begin tag = "R8"; vpct = 50; end
      11: begin tag = "R1"; smode = 2; pmode = 1; span_b = 3; gain_b = 16; core_b = 0; lim_b = 127; end
      default: vpct = 85;
    endcase
  endtask

  task automatic run_phase(int ph);
    int m, prev, lvl, got;
    bit v;
    configure(ph);
    @(negedge clk);
    rst = 1'b1; pix_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R9 reset output", int'($signed(svm_out)), 0);
    rst = 1'b0;
    m = 0; prev = 0; lvl = 0;
    while (m < NPIX) begin
      v = (($urandom % 100) < vpct);
      pix_valid = v;
      if (pmode == 1) begin
        if (m % 5 == 0) lvl = (lvl == 0) ? 1023 : 0;
        red = 10'(lvl); grn = 10'(lvl); blu = 10'(lvl);
      end else if (pmode == 2) begin
        red = 10'(500 + $urandom % 16); grn = 10'(500 + $urandom % 16); blu = 10'(500 + $urandom % 16);
      end else begin
        red = 10'($urandom % 1024); grn = 10'($urandom % 1024); blu = 10'($urandom % 1024);
      end
      set_sel = (smode == 0) ? 1'b0 : (smode == 2) ? 1'b1 : 1'($urandom % 2);
      if (!v) begin
        red = 10'($urandom % 1024); grn = 10'($urandom % 1024); set_sel = ~set_sel;
      end else begin
        y_arr[m]   = luma(int'(red), int'(grn), int'(blu));
        sel_arr[m] = set_sel;
      end
      @(negedge clk);
      got = int'($signed(svm_out));
      if (v) begin
        check(tag, got, expect_out(m));
        m++;
      end else begin
        check("R8 hold", got, prev);
      end
      prev = got;
    end
    pix_valid = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int ph = 0; ph < NPH; ph++) run_phase(ph);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule